// File: doc/BRIEF.md
# Configuration Access Bridge

This block turns a PCI configuration request (bus, device, function, 12-bit register offset, access size and write data) into a single 32-bit word address on a downstream register bus and carries out the access. Bus 0 is special: its devices are the root ports of the controller. Device number N on bus 0 selects root port N-1, and the access lands in that port's own register window. Any other bus number is sent into one shared extended configuration window. The offset inside that window is built by packing the bus, device, function and register offset into one word.

Byte and halfword writes are turned into a read-modify-write of the aligned word. Sub-word reads return the selected lanes shifted down and zero-extended. A request that cannot be routed never reaches the downstream bus: a read returns all ones and a write is dropped but still acknowledged.

Two strap inputs turn on older behaviours. The first allows only device 0 behind any non-zero bus. The second makes bus-0 reads of the class/revision dword report a PCI-to-PCI bridge class code. The host side takes one request at a time through a valid/ready handshake. The downstream side issues one access at a time and holds it until the memory accepts it.

Top module: `cfg_addr_bridge`

## Requirements
- R1: After synchronous reset, req_ready is 1 and mem_valid, rd_valid and wr_done are 0.
- R2: On bus 0, a device number N with 1 <= N <= NUM_RP whose enable bit rp_en[N-1] is set addresses rp_base slice N-1 (bits (N-1)*32 upward) plus the register offset with bits 1:0 cleared.
- R3: On a non-zero bus, the address is win_base plus a packed offset:
  - offset bits 11:8 at 27:24
  - bus at 23:16
  - device at 15:11
  - function at 10:8
  - offset bits 7:2 at 7:2
  - all other bits zero.
- R4: A bus-0 request is unroutable when its device is 0, its device is above NUM_RP, or its port is disabled. An unroutable read returns 32'hFFFFFFFF whatever the size. An unroutable write completes with wr_done and makes no downstream access.
- R5: The req_size encoding is 0 = byte, 1 = halfword, 2 or 3 = word.
  - A byte read returns the byte at lane off[1:0], zero-extended.
  - A halfword read returns the half selected by off[1] (off[0] is ignored), zero-extended.
  - A word read returns the whole word.
- R6: A byte or halfword write makes exactly one downstream read of the aligned word. It then makes one write of that word, with only the addressed lanes replaced from the low bits of req_wdata. A word write makes a single downstream write and no read.
- R7: With strap_dev0_only at 1, a non-zero-bus request with a non-zero device is unroutable (as in R4). With the strap at 0, such a request is routed.
- R8: With strap_class_fix at 1, a routed bus-0 read of the dword at offset 0x008 reports bits 23:16 as BRIDGE_CLASS (default 8'h06), before any sub-word extraction. Non-zero buses and other offsets are unaffected, and with the strap at 0 the raw word is returned.
- R9: Only one request is accepted at a time, and req_ready is 0 while a request is in flight. mem_valid, mem_write, mem_addr and mem_wdata stay stable until mem_ready. An access completes in the cycle where mem_valid and mem_ready are both 1, and mem_rdata is taken in that cycle.
- R10: A read finishes with a one-cycle rd_valid pulse carrying rd_data, and a write with a one-cycle wr_done pulse. The pulse comes in the cycle after the last downstream handshake, or after acceptance if the request makes no downstream access. req_ready returns in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_dev0_only | input | 1 | Reject non-zero device numbers behind non-zero buses |
| strap_class_fix | input | 1 | Force the bridge class code on bus-0 class/revision reads |
| rp_base | input | NUM_RP*32 | Root-port window bases, port i in bits i*32 upward |
| rp_en | input | NUM_RP | Root-port enable bits |
| win_base | input | 32 | Extended configuration window base |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 12 | Register byte offset |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, right-aligned |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 32 | Read result |
| wr_done | output | 1 | Write completion pulse |
| mem_valid | output | 1 | Downstream access valid |
| mem_ready | input | 1 | Downstream access accepted |
| mem_write | output | 1 | Downstream access is a write |
| mem_addr | output | 32 | Downstream word address (bits 1:0 zero) |
| mem_wdata | output | 32 | Downstream write word |
| mem_rdata | input | 32 | Downstream read word, valid with mem_ready |

## Verification
The bound checker watches these rules on every cycle:
- Downstream requests stay stable while stalled.
- No request is accepted while busy.
- A sub-word write never writes before it has read.
- Every completed downstream access is followed at once by the matching pulse.
- No transaction makes more downstream accesses than its kind allows.

Only the bench scenarios can show that the numeric results are right. These are the bus-0 port selection, the packed window offset, and the lane choice for extraction and merging. They also cover the all-ones result and the missing access for unroutable requests, and both straps turned on and off.

// File: rtl/cfg_bridge_pkg.sv
// Shared types and constants for the configuration access bridge.
// Assumes a 32-bit downstream data path.
package cfg_bridge_pkg;

    localparam int DW = 32;
    localparam int PACK_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD3 = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_RESP = 2'd3
    } seq_state_e;

    // Dword index (offset bits 11:2) of the class/revision register
    localparam logic [9:0] CLASS_DW_IDX = 10'h002;
    localparam logic [DW-1:0] ALL_ONES = '1;

endpackage

// File: rtl/cfg_route.sv
// Address router: decides whether a configuration request is routable and
// computes its downstream word address. Bus 0 selects a root-port window
// by device number (device N -> port N-1); other buses go to the extended
// window through a packed offset. Purely combinational; assumes AW >= 32.
module cfg_route
    import cfg_bridge_pkg::*;
#(
    parameter int NUM_RP = 3,
    parameter int AW     = 32
) (
    input  logic [7:0]           bus_i,
    input  logic [4:0]           dev_i,
    input  logic [2:0]           func_i,
    input  logic [9:0]           off_dw_i,
    input  logic [NUM_RP*AW-1:0] rp_base_i,
    input  logic [NUM_RP-1:0]    rp_en_i,
    input  logic [AW-1:0]        win_base_i,
    input  logic                 dev0_only_i,
    output logic                 hit_o,
    output logic [AW-1:0]        addr_o,
    output logic                 class_dw_o
);

    logic [NUM_RP-1:0] port_match;
    logic [AW-1:0]     masked_base [NUM_RP];
    logic [AW-1:0]     base_sel;
    logic [PACK_W-1:0] packed_off;
    logic [AW-1:0]     root_sum;
    logic [AW-1:0]     win_sum;
    logic              is_root;

    // One comparator per root port: match when enabled and device == index+1
    for (genvar g = 0; g < NUM_RP; g++) begin : g_port
        assign port_match[g]  = rp_en_i[g] && (dev_i == 5'(g + 1));
        assign masked_base[g] = port_match[g] ? rp_base_i[g*AW +: AW] : '0;
    end

    // OR-combine the (at most one) selected port base
    always_comb begin
        base_sel = '0;
        for (int i = 0; i < NUM_RP; i++) begin
            base_sel = base_sel | masked_base[i];
        end
    end

    // Packed extended-window offset: upper offset nibble sits above the bus
    assign packed_off = {4'h0, off_dw_i[9:6], bus_i, dev_i, func_i, off_dw_i[5:0], 2'b00};

    // Candidate addresses and the routing decision
    always_comb begin
        is_root    = (bus_i == 8'h00);
        root_sum   = base_sel + AW'({off_dw_i, 2'b00});
        win_sum    = win_base_i + AW'(packed_off);
        hit_o      = is_root ? (|port_match) : !(dev0_only_i && (dev_i != 5'd0));
        addr_o     = (is_root ? root_sum : win_sum) & ~AW'(3);
        class_dw_o = is_root && (off_dw_i == CLASS_DW_IDX);
    end

endmodule

// File: rtl/cfg_lane.sv
// Byte-lane unit: extracts a zero-extended byte/halfword/word from a 32-bit
// word and merges right-aligned write data into the addressed lanes.
// Halfword lane is chosen by lane_i[1]; lane_i[0] is ignored for halves.
module cfg_lane
    import cfg_bridge_pkg::*;
(
    input  logic [1:0]    size_i,
    input  logic [1:0]    lane_i,
    input  logic [DW-1:0] word_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] merged_o,
    output logic [DW-1:0] extract_o
);

    localparam int NB = DW / 8;

    logic [NB-1:0] byte_en;
    logic [DW-1:0] rep_data;
    logic [4:0]    shamt;
    logic [DW-1:0] shifted;

    // Byte enables, replicated write data and read shift per size code
    always_comb begin
        case (acc_size_e'(size_i))
            SZ_BYTE: begin
                byte_en  = NB'(1) << lane_i;
                rep_data = {NB{wdata_i[7:0]}};
                shamt    = {lane_i, 3'b000};
            end
            SZ_HALF: begin
                byte_en  = lane_i[1] ? 4'b1100 : 4'b0011;
                rep_data = {2{wdata_i[15:0]}};
                shamt    = {lane_i[1], 4'b0000};
            end
            default: begin
                byte_en  = '1;
                rep_data = wdata_i;
                shamt    = 5'd0;
            end
        endcase
    end

    // Per-lane merge of new bytes over the old word
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign merged_o[b*8 +: 8] = byte_en[b] ? rep_data[b*8 +: 8] : word_i[b*8 +: 8];
    end

    // Shift the selected lanes down and zero-extend
    always_comb begin
        shifted = word_i >> shamt;
        case (acc_size_e'(size_i))
            SZ_BYTE: extract_o = {24'h0, shifted[7:0]};
            SZ_HALF: extract_o = {16'h0, shifted[15:0]};
            default: extract_o = shifted;
        endcase
    end

endmodule

// File: rtl/cfg_seq.sv
// Transaction sequencer: accepts one request, runs the read, read-modify-write
// or write on the downstream bus, then pulses a one-cycle response.
// Assumes route results and fixup flag are valid with the request.
module cfg_seq
    import cfg_bridge_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [1:0]    req_lane,
    input  logic [DW-1:0] req_wdata,
    input  logic          route_hit,
    input  logic [AW-1:0] route_addr,
    input  logic          fix_req,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] lane_merged,
    input  logic [DW-1:0] lane_extract,
    output logic [1:0]    cur_size,
    output logic [1:0]    cur_lane,
    output logic [DW-1:0] cur_data,
    output logic          cur_fix,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          wr_done
);

    seq_state_e    st;
    logic          wr_q;
    logic [1:0]    sz_q;
    logic [1:0]    lane_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rdata_q;
    logic          fix_q;
    logic          sub_word;

    assign sub_word = (req_size == SZ_BYTE) || (req_size == SZ_HALF);

    // State and transaction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            wr_q    <= 1'b0;
            sz_q    <= 2'd0;
            lane_q  <= 2'd0;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
            fix_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q   <= req_write;
                        sz_q   <= req_size;
                        lane_q <= req_lane;
                        addr_q <= route_addr;
                        data_q <= req_wdata;
                        fix_q  <= fix_req;
                        if (!route_hit) begin
                            rdata_q <= ALL_ONES;
                            st      <= ST_RESP;
                        end else if (!req_write || sub_word) begin
                            st <= ST_RD;
                        end else begin
                            st <= ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (mem_ready) begin
                        if (wr_q) begin
                            data_q <= lane_merged;
                            st     <= ST_WR;
                        end else begin
                            rdata_q <= lane_extract;
                            st      <= ST_RESP;
                        end
                    end
                end
                ST_WR: begin
                    if (mem_ready) begin
                        st <= ST_RESP;
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    // Moore outputs decoded from the state registers
    always_comb begin
        req_ready = (st == ST_IDLE);
        mem_valid = (st == ST_RD) || (st == ST_WR);
        mem_write = (st == ST_WR);
        mem_addr  = addr_q;
        mem_wdata = data_q;
        rd_valid  = (st == ST_RESP) && !wr_q;
        wr_done   = (st == ST_RESP) && wr_q;
        rd_data   = rdata_q;
        cur_size  = sz_q;
        cur_lane  = lane_q;
        cur_data  = data_q;
        cur_fix   = fix_q;
    end

endmodule

// File: rtl/cfg_addr_bridge.sv
// Configuration access bridge top: routes a bus/device/function/offset
// request to a root-port window (bus 0) or the extended configuration
// window (other buses), merges sub-word writes by read-modify-write and
// returns all ones for unroutable reads. One request in flight at a time.
// Assumes word-aligned window bases.
module cfg_addr_bridge
    import cfg_bridge_pkg::*;
#(
    parameter int         NUM_RP       = 3,
    parameter int         AW           = 32,
    parameter logic [7:0] BRIDGE_CLASS = 8'h06
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_dev0_only,
    input  logic                 strap_class_fix,
    input  logic [NUM_RP*AW-1:0] rp_base,
    input  logic [NUM_RP-1:0]    rp_en,
    input  logic [AW-1:0]        win_base,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [7:0]           req_bus,
    input  logic [4:0]           req_dev,
    input  logic [2:0]           req_func,
    input  logic [11:0]          req_off,
    input  logic [1:0]           req_size,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data,
    output logic                 wr_done,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic                 mem_write,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata
);

    logic          route_hit;
    logic [AW-1:0] route_addr;
    logic          class_dw;
    logic          fix_req;
    logic [1:0]    cur_size;
    logic [1:0]    cur_lane;
    logic [DW-1:0] cur_data;
    logic          cur_fix;
    logic [DW-1:0] fixed_word;
    logic [DW-1:0] lane_merged;
    logic [DW-1:0] lane_extract;

    cfg_route #(
        .NUM_RP (NUM_RP),
        .AW     (AW)
    ) u_route (
        .bus_i       (req_bus),
        .dev_i       (req_dev),
        .func_i      (req_func),
        .off_dw_i    (req_off[11:2]),
        .rp_base_i   (rp_base),
        .rp_en_i     (rp_en),
        .win_base_i  (win_base),
        .dev0_only_i (strap_dev0_only),
        .hit_o       (route_hit),
        .addr_o      (route_addr),
        .class_dw_o  (class_dw)
    );

    // Class fixup applies only to reads of the bus-0 class/revision dword
    assign fix_req = strap_class_fix && class_dw && !req_write;

    // Patch the class byte of the returned word when the fixup is armed
    assign fixed_word = cur_fix ? {mem_rdata[31:24], BRIDGE_CLASS, mem_rdata[15:0]} : mem_rdata;

    cfg_lane u_lane (
        .size_i    (cur_size),
        .lane_i    (cur_lane),
        .word_i    (fixed_word),
        .wdata_i   (cur_data),
        .merged_o  (lane_merged),
        .extract_o (lane_extract)
    );

    cfg_seq #(
        .AW (AW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_size     (req_size),
        .req_lane     (req_off[1:0]),
        .req_wdata    (req_wdata),
        .route_hit    (route_hit),
        .route_addr   (route_addr),
        .fix_req      (fix_req),
        .mem_valid    (mem_valid),
        .mem_write    (mem_write),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ready    (mem_ready),
        .lane_merged  (lane_merged),
        .lane_extract (lane_extract),
        .cur_size     (cur_size),
        .cur_lane     (cur_lane),
        .cur_data     (cur_data),
        .cur_fix      (cur_fix),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .wr_done      (wr_done)
    );

endmodule

// File: rtl/cfg_addr_bridge_chk.sv
// Protocol checker for the configuration access bridge, bound to the top.
// Tracks per-transaction kind and downstream access count from the ports.
module cfg_addr_bridge_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic [1:0]    req_size,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_write,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          rd_valid,
    input logic          wr_done
);

    logic       sub_q;
    logic       wr_q;
    logic       rd_seen;
    logic [1:0] acc_cnt;

    // Record transaction kind at acceptance and count downstream accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q   <= 1'b0;
            wr_q    <= 1'b0;
            rd_seen <= 1'b0;
            acc_cnt <= 2'd0;
        end else if (req_valid && req_ready) begin
            sub_q   <= (req_size == 2'd0) || (req_size == 2'd1);
            wr_q    <= req_write;
            rd_seen <= 1'b0;
            acc_cnt <= 2'd0;
        end else if (mem_valid && mem_ready) begin
            if (acc_cnt != 2'd3) acc_cnt <= acc_cnt + 2'd1;
            if (!mem_write) rd_seen <= 1'b1;
        end
    end

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

    p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    p_rmw_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && sub_q) |-> rd_seen);

    p_word_write_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && wr_q && !sub_q) |-> mem_write);

    p_write_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && mem_ready) |=> wr_done);

    p_read_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write && mem_ready && !wr_q) |=> rd_valid);

    p_pulse_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_done) |=> (req_ready && !rd_valid && !wr_done));

    p_read_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (acc_cnt <= 2'd1));

    p_write_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> (acc_cnt <= 2'd2));

endmodule

bind cfg_addr_bridge cfg_addr_bridge_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rd_valid  (rd_valid),
    .wr_done   (wr_done)
);

// File: tb/sim_cfg_addr_bridge.sv
`timescale 1ns/1ps
module sim_cfg_addr_bridge;

    localparam int NUM_RP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_dev0_only = 1'b0;
    logic          strap_class_fix = 1'b0;
    logic [95:0]   rp_base = {32'h1002_0000, 32'h1001_0000, 32'h1000_0000};
    logic [2:0]    rp_en = 3'b111;
    logic [31:0]   win_base = 32'h2000_0000;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [7:0]    req_bus = '0;
    logic [4:0]    req_dev = '0;
    logic [2:0]    req_func = '0;
    logic [11:0]   req_off = '0;
    logic [1:0]    req_size = '0;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          wr_done;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic          mem_write;
    logic [31:0]   mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    always #4 clk = ~clk;

    cfg_addr_bridge #(.NUM_RP(NUM_RP)) u0 (.*);

    // Downstream memory model with programmable latency
    logic [31:0] mem_model [logic [31:0]];
    int          lat_cfg = 0;
    int          lat_cnt = 0;
    int          n_rd = 0;
    int          n_wr = 0;
    logic [31:0] last_addr = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            lat_cnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_valid) begin
            if (lat_cnt >= lat_cfg) begin
                lat_cnt = 0;
                mem_ready = 1'b1;
                last_addr = mem_addr;
                if (mem_write) begin
                    mem_model[mem_addr] = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 32'h0;
                    n_rd++;
                end
            end else begin
                lat_cnt++;
            end
        end
    end

    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem_model.exists(a) ? mem_model[a] : 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One transaction; reports data, busy flag after accept and pulse shape
    task automatic xfer(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                        input logic [2:0] fn, input logic [11:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rdat,
                        output logic busy_ok, output logic pulse_ok);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
        req_func = fn; req_off = off; req_size = sz; req_wdata = wd;
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = !req_ready;
        guard = 0;
        while (!(rd_valid || wr_done) && guard < 200) begin @(negedge clk); guard++; end
        if (guard >= 200) chk("R10 response timeout", 32'h0, 32'h1);
        rdat = rd_data;
        @(negedge clk);
        pulse_ok = !rd_valid && !wr_done && req_ready;
    endtask

    typedef struct packed {
        logic [3:0]  rq;
        logic        wr;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] off;
        logic [1:0]  sz;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [31:0] addr;
        logic [1:0]  nrd;
        logic [1:0]  nwr;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b0, 8'h00, 5'd1,  3'd0, 12'h000, 2'd2, 32'h0,        32'h1122_3344, 32'h1000_0000, 2'd1, 2'd0}, // R2
        '{4'd5, 1'b0, 8'h00, 5'd1,  3'd0, 12'h001, 2'd0, 32'h0,        32'h0000_0033, 32'h1000_0000, 2'd1, 2'd0}, // R5
        '{4'd5, 1'b0, 8'h00, 5'd1,  3'd0, 12'h003, 2'd0, 32'h0,        32'h0000_0011, 32'h1000_0000, 2'd1, 2'd0}, // R5
        '{4'd5, 1'b0, 8'h00, 5'd1,  3'd0, 12'h002, 2'd1, 32'h0,        32'h0000_1122, 32'h1000_0000, 2'd1, 2'd0}, // R5
        '{4'd5, 1'b0, 8'h00, 5'd1,  3'd0, 12'h000, 2'd1, 32'h0,        32'h0000_3344, 32'h1000_0000, 2'd1, 2'd0}, // R5
        '{4'd3, 1'b0, 8'h01, 5'd2,  3'd3, 12'h10C, 2'd2, 32'h0,        32'hCAFE_F00D, 32'h2101_130C, 2'd1, 2'd0}, // R3
        '{4'd3, 1'b0, 8'h80, 5'd31, 3'd7, 12'hFFF, 2'd0, 32'h0,        32'h0000_0001, 32'h2F80_FFFC, 2'd1, 2'd0}, // R3
        '{4'd2, 1'b0, 8'h00, 5'd3,  3'd0, 12'hFFC, 2'd3, 32'h0,        32'h5A5A_A5A5, 32'h1002_0FFC, 2'd1, 2'd0}, // R2
        '{4'd4, 1'b0, 8'h00, 5'd0,  3'd0, 12'h000, 2'd2, 32'h0,        32'hFFFF_FFFF, 32'h0,         2'd0, 2'd0}, // R4
        '{4'd4, 1'b0, 8'h00, 5'd4,  3'd0, 12'h001, 2'd0, 32'h0,        32'hFFFF_FFFF, 32'h0,         2'd0, 2'd0}, // R4
        '{4'd6, 1'b1, 8'h00, 5'd1,  3'd0, 12'h001, 2'd0, 32'h0000_00EE, 32'h1122_EE44, 32'h1000_0000, 2'd1, 2'd1}, // R6
        '{4'd6, 1'b1, 8'h00, 5'd1,  3'd0, 12'h002, 2'd1, 32'h0000_BEEF, 32'hBEEF_EE44, 32'h1000_0000, 2'd1, 2'd1}, // R6
        '{4'd6, 1'b1, 8'h01, 5'd2,  3'd3, 12'h10C, 2'd2, 32'h1234_5678, 32'h1234_5678, 32'h2101_130C, 2'd0, 2'd1}, // R6
        '{4'd4, 1'b1, 8'h00, 5'd0,  3'd0, 12'h000, 2'd2, 32'h0000_DEAD, 32'hBEEF_EE44, 32'h1000_0000, 2'd0, 2'd0}, // R4
        '{4'd5, 1'b0, 8'h00, 5'd1,  3'd0, 12'h001, 2'd1, 32'h0,        32'h0000_EE44, 32'h1000_0000, 2'd1, 2'd0}, // R5
        '{4'd6, 1'b1, 8'h05, 5'd0,  3'd0, 12'h003, 2'd0, 32'h0000_00AB, 32'hAB00_0000, 32'h2005_0000, 2'd1, 2'd1}, // R6
        '{4'd8, 1'b0, 8'h00, 5'd2,  3'd0, 12'h008, 2'd2, 32'h0,        32'hAABB_CCDD, 32'h1001_0008, 2'd1, 2'd0}  // R8
    };

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic        busy_ok;
        logic        pulse_ok;
        int          rd0;
        int          wr0;

        mem_model[32'h1000_0000] = 32'h1122_3344;
        mem_model[32'h1001_0008] = 32'hAABB_CCDD;
        mem_model[32'h1001_000C] = 32'h9988_7766;
        mem_model[32'h1002_0FFC] = 32'h5A5A_A5A5;
        mem_model[32'h2101_130C] = 32'hCAFE_F00D;
        mem_model[32'h2F80_FFFC] = 32'h0102_0304;
        mem_model[32'h2001_0000] = 32'h7766_5544;
        mem_model[32'h2001_0008] = 32'h0B0C_0D0E;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
        chk("R1 mem_valid", {31'h0, mem_valid}, 32'h0);
        chk("R1 rd_valid/wr_done", {30'h0, rd_valid, wr_done}, 32'h0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            rd0 = n_rd;
            wr0 = n_wr;
            xfer(VECS[i].wr, VECS[i].bus, VECS[i].dev, VECS[i].fn, VECS[i].off,
                 VECS[i].sz, VECS[i].wd, got, busy_ok, pulse_ok);
            if (VECS[i].wr)
                chk($sformatf("R%0d vec%0d memory word", VECS[i].rq, i), peek(VECS[i].addr), VECS[i].exp);
            else
                chk($sformatf("R%0d vec%0d read data", VECS[i].rq, i), got, VECS[i].exp);
            chk($sformatf("R%0d vec%0d read count", VECS[i].rq, i), 32'(n_rd - rd0), 32'(VECS[i].nrd));
            chk($sformatf("R%0d vec%0d write count", VECS[i].rq, i), 32'(n_wr - wr0), 32'(VECS[i].nwr));
            if (VECS[i].nrd + VECS[i].nwr != 0)
                chk($sformatf("R%0d vec%0d address", VECS[i].rq, i), last_addr, VECS[i].addr);
        end

        // R7: device-0-only strap
        strap_dev0_only = 1'b1;
        rd0 = n_rd;
        xfer(1'b0, 8'h01, 5'd2, 3'd3, 12'h10C, 2'd2, 32'h0, got, busy_ok, pulse_ok);
        chk("R7 nonzero dev read data", got, 32'hFFFF_FFFF);
        chk("R7 nonzero dev no access", 32'(n_rd - rd0), 32'h0);
        xfer(1'b0, 8'h01, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, got, busy_ok, pulse_ok);
        chk("R7 dev0 routed data", got, 32'h7766_5544);
        chk("R7 dev0 routed address", last_addr, 32'h2001_0000);
        wr0 = n_wr;
        xfer(1'b1, 8'h01, 5'd2, 3'd3, 12'h10C, 2'd2, 32'hFFFF_0000, got, busy_ok, pulse_ok);
        chk("R7 dropped write memory", peek(32'h2101_130C), 32'h1234_5678);
        chk("R7 dropped write count", 32'(n_wr - wr0), 32'h0);
        strap_dev0_only = 1'b0;

        // R8: class fixup strap
        strap_class_fix = 1'b1;
        xfer(1'b0, 8'h00, 5'd2, 3'd0, 12'h008, 2'd2, 32'h0, got, busy_ok, pulse_ok);
        chk("R8 class word", got, 32'hAA06_CCDD);
        xfer(1'b0, 8'h00, 5'd2, 3'd0, 12'h00A, 2'd0, 32'h0, got, busy_ok, pulse_ok);
        chk("R8 class byte", got, 32'h0000_0006);
        xfer(1'b0, 8'h00, 5'd2, 3'd0, 12'h009, 2'd0, 32'h0, got, busy_ok, pulse_ok);
        chk("R8 neighbour byte", got, 32'h0000_00CC);
        xfer(1'b0, 8'h00, 5'd2, 3'd0, 12'h00C, 2'd2, 32'h0, got, busy_ok, pulse_ok);
        chk("R8 other dword raw", got, 32'h9988_7766);
        xfer(1'b0, 8'h01, 5'd0, 3'd0, 12'h008, 2'd2, 32'h0, got, busy_ok, pulse_ok);
        chk("R8 nonzero bus raw", got, 32'h0B0C_0D0E);
        strap_class_fix = 1'b0;

        // R4: disabled root port
        rp_en = 3'b101;
        rd0 = n_rd;
        xfer(1'b0, 8'h00, 5'd2, 3'd0, 12'h008, 2'd2, 32'h0, got, busy_ok, pulse_ok);
        chk("R4 disabled port data", got, 32'hFFFF_FFFF);
        chk("R4 disabled port no access", 32'(n_rd - rd0), 32'h0);
        xfer(1'b0, 8'h00, 5'd3, 3'd0, 12'hFFC, 2'd2, 32'h0, got, busy_ok, pulse_ok);
        chk("R4 enabled neighbour data", got, 32'h5A5A_A5A5);
        rp_en = 3'b111;

        // R9 / R10: stalled downstream and pulse shape
        lat_cfg = 3;
        xfer(1'b0, 8'h00, 5'd1, 3'd0, 12'h000, 2'd2, 32'h0, got, busy_ok, pulse_ok);
        chk("R9 stalled read data", got, 32'hBEEF_EE44);
        chk("R9 busy after accept", {31'h0, busy_ok}, 32'h1);
        chk("R10 read pulse one cycle", {31'h0, pulse_ok}, 32'h1);
        rd0 = n_rd;
        wr0 = n_wr;
        xfer(1'b1, 8'h00, 5'd3, 3'd0, 12'hFFE, 2'd1, 32'h0000_1234, got, busy_ok, pulse_ok);
        chk("R9 stalled rmw memory", peek(32'h1002_0FFC), 32'h1234_A5A5);
        chk("R9 stalled rmw accesses", 32'(n_rd - rd0 + n_wr - wr0), 32'h2);
        chk("R10 write pulse one cycle", {31'h0, pulse_ok}, 32'h1);
        lat_cfg = 0;
        xfer(1'b1, 8'h00, 5'd0, 3'd0, 12'h000, 2'd0, 32'h0, got, busy_ok, pulse_ok);
        chk("R10 unroutable write pulse", {31'h0, pulse_ok}, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule